// File: doc/BRIEF.md
# Replayable Lagged-Sum Random Word Generator

This block supplies pseudo-random 36-bit words to a memory test sequencer. It keeps a table of eight words, a running sum and a signed index. Each step adds the selected table word to the running sum, writes the new sum into both the running sum and that table word, and moves the index down by one. When the index has passed zero, the step uses the last table word and sets the index back to six. The generator is a lagged additive one, not a shift register.

A test writes a region with one stretch of the sequence and later checks it with the same stretch. To do this the sequencer pulses `mark_i` before the write pass, which copies the whole generator state into a shadow copy. It pulses `restore_i` before the verify pass, which loads the shadow copy back so the same words come out again. With `skip_en_i` high, any word whose instruction-like fields hold a reserved code is dropped. The generator then steps again on the following cycles, and only an accepted word raises `valid_o`.

Top module: `lagsum_rng`

## Requirements
- R1: During and right after reset `valid_o` is 0 and `data_o` is 0. The table is seeded (octal) with entry0=7654321, entry1=76543210, entry2=765432100, entry3=7654321000, entry4=76543210000, entry5=765432100000, entry6=654321000007 and entry7=543210000076. The running sum starts equal to entry7 and the index starts at 7.
- R2: A step with a non-negative index k forms sum + entry k modulo 2^36. It writes the result to the running sum and to entry k, then sets the index to k-1.
- R3: A step with a negative index uses entry 7. It writes the result to the running sum and to entry 7, then sets the index to 6.
- R4: With `skip_en_i` low, a `next_i` pulse sampled at a clock edge gives the stepped word on `data_o` with `valid_o` high for exactly the following cycle.
- R5: `mark_i` copies all eight entries, the running sum and the index into the shadow copy in one cycle. If `next_i` is high in the same cycle, the copy holds the state from before that step.
- R6: `restore_i` loads the shadow copy into the live state in one cycle, so the words that follow repeat those that followed the mark. Before any mark, the shadow copy holds the reset state.
- R7: `restore_i` takes precedence: a `next_i` or `mark_i` in the same cycle is ignored, and `valid_o` is low in the following cycle.
- R8: With `skip_en_i` high, a word w is rejected when (w AND octal 7600000000) equals octal 1600000000, or when (w AND octal 174000000) equals octal 034000000. These are the two fields compared with their reserved code after XOR with octal 1634000000. A rejected word never raises `valid_o`, and the generator steps again on each following cycle until a word is accepted. With `skip_en_i` low, such words are delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| next_i | input | 1 | Request one accepted word |
| mark_i | input | 1 | Copy generator state to shadow copy |
| restore_i | input | 1 | Load generator state from shadow copy |
| skip_en_i | input | 1 | Reject words carrying the reserved field codes |
| data_o | output | 36 | Last accepted word |
| valid_o | output | 1 | One-cycle strobe for a new word |

## Verification
Two pairs of operations can land on the same edge. The first is a mark together with a request: the bench raises both in one cycle and expects a later restore to replay the very word that request produced. The second is a restore together with a request (and, separately, a mark): the bench raises both, expects no strobe in the next cycle, and expects the following words to match the replayed stretch. This proves the request and the mark were both dropped.

// File: rtl/lagsum_pkg.sv
package lagsum_pkg;

   localparam int WORD_W   = 36;
   localparam int TABLE_N  = 8;
   localparam int N_FIELDS = 2;

   typedef logic [WORD_W-1:0] word_t;

   // key applied before the field compare; a field that becomes zero is a reserved code
   localparam word_t XOR_KEY = 36'o001634000000;
   localparam logic [N_FIELDS-1:0][WORD_W-1:0] FIELD_MASK = {36'o000174000000, 36'o007600000000};

   function automatic word_t seed_word(input int unsigned i);
      case (i)
         0: seed_word = 36'o000007654321;
         1: seed_word = 36'o000076543210;
         2: seed_word = 36'o000765432100;
         3: seed_word = 36'o007654321000;
         4: seed_word = 36'o076543210000;
         5: seed_word = 36'o765432100000;
         6: seed_word = 36'o654321000007;
         default: seed_word = 36'o543210000076;
      endcase
   endfunction

endpackage

// File: rtl/lagsum_core.sv
module lagsum_core
   import lagsum_pkg::*;
#(
   parameter int WORD_W  = lagsum_pkg::WORD_W,
   parameter int TABLE_N = lagsum_pkg::TABLE_N
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        step_i,
   input  logic                        load_i,
   input  logic [TABLE_N*WORD_W-1:0]   ld_tbl_i,
   input  logic [WORD_W-1:0]           ld_sum_i,
   input  logic [$clog2(TABLE_N):0]    ld_idx_i,
   output logic [TABLE_N*WORD_W-1:0]   tbl_o,
   output logic [WORD_W-1:0]           sum_o,
   output logic [$clog2(TABLE_N):0]    idx_o,
   output logic [WORD_W-1:0]           sum_next_o
);

   localparam int SEL_W = $clog2(TABLE_N);
   localparam int IDX_W = SEL_W + 1;

   logic [WORD_W-1:0] tbl_q [TABLE_N];
   logic [WORD_W-1:0] sum_q;
   logic [IDX_W-1:0]  idx_q;
   logic              idx_neg;
   logic [SEL_W-1:0]  sel;

   assign idx_neg    = idx_q[IDX_W-1];
   assign sel        = idx_neg ? SEL_W'(TABLE_N-1) : idx_q[SEL_W-1:0];
   assign sum_next_o = sum_q + tbl_q[sel];

   for (genvar e = 0; e < TABLE_N; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            tbl_q[e] <= WORD_W'(seed_word(e));
         else if (load_i)
            tbl_q[e] <= ld_tbl_i[e*WORD_W +: WORD_W];
         else if (step_i && (sel == SEL_W'(e)))
            tbl_q[e] <= sum_next_o;
      end
      assign tbl_o[e*WORD_W +: WORD_W] = tbl_q[e];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q <= WORD_W'(seed_word(TABLE_N-1));
         idx_q <= IDX_W'(TABLE_N-1);
      end else if (load_i) begin
         sum_q <= ld_sum_i;
         idx_q <= ld_idx_i;
      end else if (step_i) begin
         sum_q <= sum_next_o;
         idx_q <= idx_neg ? IDX_W'(TABLE_N-2) : idx_q - 1'b1;
      end
   end

   assign sum_o = sum_q;
   assign idx_o = idx_q;

   assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (rst)
      (step_i && !load_i && idx_neg) |=> (idx_q == IDX_W'(TABLE_N-2)));

   assert_entry_matches_sum_R2: assert property (@(posedge clk) disable iff (rst)
      (step_i && !load_i) |=> (sum_q == tbl_q[$past(sel)]));

endmodule

// File: rtl/lagsum_snap.sv
module lagsum_snap
   import lagsum_pkg::*;
#(
   parameter int WORD_W  = lagsum_pkg::WORD_W,
   parameter int TABLE_N = lagsum_pkg::TABLE_N
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        capture_i,
   input  logic [TABLE_N*WORD_W-1:0]   cur_tbl_i,
   input  logic [WORD_W-1:0]           cur_sum_i,
   input  logic [$clog2(TABLE_N):0]    cur_idx_i,
   output logic [TABLE_N*WORD_W-1:0]   sv_tbl_o,
   output logic [WORD_W-1:0]           sv_sum_o,
   output logic [$clog2(TABLE_N):0]    sv_idx_o
);

   localparam int IDX_W = $clog2(TABLE_N) + 1;

   for (genvar e = 0; e < TABLE_N; e++) begin : g_shadow
      logic [WORD_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (rst)
            ent_q <= WORD_W'(seed_word(e));
         else if (capture_i)
            ent_q <= cur_tbl_i[e*WORD_W +: WORD_W];
      end
      assign sv_tbl_o[e*WORD_W +: WORD_W] = ent_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sv_sum_o <= WORD_W'(seed_word(TABLE_N-1));
         sv_idx_o <= IDX_W'(TABLE_N-1);
      end else if (capture_i) begin
         sv_sum_o <= cur_sum_i;
         sv_idx_o <= cur_idx_i;
      end
   end

   assert_capture_pre_step_R5: assert property (@(posedge clk) disable iff (rst)
      capture_i |=> (sv_sum_o == $past(cur_sum_i)) && (sv_idx_o == $past(cur_idx_i)));

endmodule

// File: rtl/lagsum_screen.sv
module lagsum_screen
   import lagsum_pkg::*;
#(
   parameter int WORD_W   = lagsum_pkg::WORD_W,
   parameter int N_FIELDS = lagsum_pkg::N_FIELDS
) (
   input  logic [WORD_W-1:0] value_i,
   output logic              hit_o
);

   logic [N_FIELDS-1:0] field_hit;
   logic [WORD_W-1:0]   keyed;

   assign keyed = value_i ^ WORD_W'(XOR_KEY);

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      assign field_hit[f] = ((keyed & WORD_W'(FIELD_MASK[f])) == '0);
   end

   assign hit_o = |field_hit;

endmodule

// File: rtl/lagsum_rng.sv
module lagsum_rng
   import lagsum_pkg::*;
#(
   parameter int WORD_W  = lagsum_pkg::WORD_W,
   parameter int TABLE_N = lagsum_pkg::TABLE_N
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              next_i,
   input  logic              mark_i,
   input  logic              restore_i,
   input  logic              skip_en_i,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o
);

   localparam int IDX_W = $clog2(TABLE_N) + 1;

   if (WORD_W != 36) begin : g_bad_width
      $error("lagsum_rng: seeds are defined for 36-bit words only");
   end
   if (TABLE_N != 8) begin : g_bad_depth
      $error("lagsum_rng: seeds are defined for an eight-entry table only");
   end

   logic [TABLE_N*WORD_W-1:0] tbl, sv_tbl;
   logic [WORD_W-1:0]         sum, sv_sum, sum_next;
   logic [IDX_W-1:0]          idx, sv_idx;
   logic                      pending_q, start, do_step, hit, accept, capture;

   assign start   = next_i && !pending_q;
   assign do_step = (start || pending_q) && !restore_i;
   assign accept  = do_step && !(skip_en_i && hit);
   assign capture = mark_i && !restore_i;

   lagsum_core #(.WORD_W(WORD_W), .TABLE_N(TABLE_N)) core_i (
      .clk        (clk),
      .rst        (rst),
      .step_i     (do_step),
      .load_i     (restore_i),
      .ld_tbl_i   (sv_tbl),
      .ld_sum_i   (sv_sum),
      .ld_idx_i   (sv_idx),
      .tbl_o      (tbl),
      .sum_o      (sum),
      .idx_o      (idx),
      .sum_next_o (sum_next)
   );

   lagsum_snap #(.WORD_W(WORD_W), .TABLE_N(TABLE_N)) snap_i (
      .clk       (clk),
      .rst       (rst),
      .capture_i (capture),
      .cur_tbl_i (tbl),
      .cur_sum_i (sum),
      .cur_idx_i (idx),
      .sv_tbl_o  (sv_tbl),
      .sv_sum_o  (sv_sum),
      .sv_idx_o  (sv_idx)
   );

   lagsum_screen #(.WORD_W(WORD_W), .N_FIELDS(N_FIELDS)) screen_i (
      .value_i (sum_next),
      .hit_o   (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         valid_o   <= 1'b0;
         data_o    <= '0;
      end else begin
         pending_q <= do_step && skip_en_i && hit;
         valid_o   <= accept;
         if (accept)
            data_o <= sum_next;
      end
   end

   assert_restore_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      restore_i |=> !valid_o);

   assert_plain_latency_R4: assert property (@(posedge clk) disable iff (rst)
      (next_i && !restore_i && !pending_q && !skip_en_i) |=> (valid_o && data_o == $past(sum_next)));

   assert_no_reserved_out_R8: assert property (@(posedge clk) disable iff (rst)
      (valid_o && $past(skip_en_i)) |->
         ((data_o & 36'o007600000000) != 36'o001600000000) &&
         ((data_o & 36'o000174000000) != 36'o000034000000));

   assert_restore_loads_R6: assert property (@(posedge clk) disable iff (rst)
      restore_i |=> (sum == $past(sv_sum)) && (idx == $past(sv_idx)));

endmodule

// File: tb/lagsum_rng_tb.sv
module lagsum_rng_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        next_i = 1'b0, mark_i = 1'b0, restore_i = 1'b0, skip_en_i = 1'b0;
   logic [35:0] data_o;
   logic        valid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lagsum_rng dut_i (
      .clk(clk), .rst(rst), .next_i(next_i), .mark_i(mark_i),
      .restore_i(restore_i), .skip_en_i(skip_en_i),
      .data_o(data_o), .valid_o(valid_o)
   );

   // reference model built from the requirements
   logic [35:0] m_tbl [8];
   logic [35:0] m_sum;
   int          m_idx;
   logic [35:0] s_tbl [8];
   logic [35:0] s_sum;
   int          s_idx;
   int          n_rejected = 0;
   int          n_reserved_sent = 0;
   logic [35:0] exp_q [$];

   function automatic logic [35:0] seed_of(int i);
      logic [35:0] s [8];
      s[0] = 36'o000007654321; s[1] = 36'o000076543210;
      s[2] = 36'o000765432100; s[3] = 36'o007654321000;
      s[4] = 36'o076543210000; s[5] = 36'o765432100000;
      s[6] = 36'o654321000007; s[7] = 36'o543210000076;
      return s[i];
   endfunction

   function automatic bit reserved(logic [35:0] w);
      return ((w & 36'o007600000000) == 36'o001600000000) ||
             ((w & 36'o000174000000) == 36'o000034000000);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         m_tbl[i] = seed_of(i);
         s_tbl[i] = seed_of(i);
      end
      m_sum = seed_of(7); s_sum = seed_of(7);
      m_idx = 7;         s_idx = 7;
   endtask

   task automatic model_step(output logic [35:0] v);
      int k;
      if (m_idx < 0) begin k = 7; m_idx = 6; end      // R3
      else begin k = m_idx; m_idx = m_idx - 1; end    // R2
      v = m_sum + m_tbl[k];
      m_sum = v;
      m_tbl[k] = v;
   endtask

   task automatic model_mark();
      for (int i = 0; i < 8; i++) s_tbl[i] = m_tbl[i];
      s_sum = m_sum; s_idx = m_idx;
   endtask

   task automatic model_restore();
      for (int i = 0; i < 8; i++) m_tbl[i] = s_tbl[i];
      m_sum = s_sum; m_idx = s_idx;
   endtask

   // push the next word the design must accept
   task automatic model_request(bit skip);
      logic [35:0] v;
      model_step(v);
      while (skip && reserved(v)) begin
         n_rejected++;
         model_step(v);
      end
      if (!skip && reserved(v)) n_reserved_sent++;
      exp_q.push_back(v);
   endtask

   task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%o expected=%o", req, act, exp);
      end
   endtask

   // monitor: sample a quarter period after the rising edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (!rst && valid_o) begin
         if (exp_q.size() == 0)
            check(1'b0, "R7 unexpected valid", data_o, 36'o0);
         else begin
            logic [35:0] e;
            e = exp_q.pop_front();
            check(data_o == e, "R2/R3/R6/R8 word", data_o, e);
         end
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic request();
      @(negedge clk);
      next_i = 1'b1;
      model_request(skip_en_i);
      @(negedge clk);
      next_i = 1'b0;
      drain();
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0, "R1 reset valid", 36'(valid_o), 36'o0);
      check(data_o == 36'o0, "R1 reset data", data_o, 36'o0);
      rst = 1'b0;
      @(negedge clk);
      check(valid_o == 1'b0, "R1 idle valid", 36'(valid_o), 36'o0);

      // R4: one-cycle strobe one edge after the request
      next_i = 1'b1;
      model_request(1'b0);
      @(negedge clk);
      next_i = 1'b0;
      check(valid_o == 1'b1, "R4 strobe high", 36'(valid_o), 36'o1);
      @(negedge clk);
      check(valid_o == 1'b0, "R4 strobe one cycle", 36'(valid_o), 36'o0);
      drain();

      // R2, R3: run through the index wrap twice
      for (int i = 0; i < 19; i++) request();

      // R6: restore before any mark replays the reset state
      @(negedge clk); restore_i = 1'b1; model_restore();
      @(negedge clk); restore_i = 1'b0;
      for (int i = 0; i < 5; i++) request();

      // R5, R6: mark, run, restore, replay
      @(negedge clk); mark_i = 1'b1; model_mark();
      @(negedge clk); mark_i = 1'b0;
      for (int i = 0; i < 12; i++) request();
      @(negedge clk); restore_i = 1'b1; model_restore();
      @(negedge clk); restore_i = 1'b0;
      for (int i = 0; i < 12; i++) request();

      // R5: mark and next on the same edge, snapshot is pre-step
      @(negedge clk); mark_i = 1'b1; next_i = 1'b1;
      model_mark(); model_request(1'b0);
      @(negedge clk); mark_i = 1'b0; next_i = 1'b0;
      drain();
      for (int i = 0; i < 4; i++) request();

      // R7: restore with next on the same edge; next is dropped
      @(negedge clk); restore_i = 1'b1; next_i = 1'b1; model_restore();
      @(negedge clk); restore_i = 1'b0; next_i = 1'b0;
      check(valid_o == 1'b0, "R7 no strobe after restore", 36'(valid_o), 36'o0);
      for (int i = 0; i < 5; i++) request();

      // R7: restore with mark on the same edge; mark is dropped
      @(negedge clk); restore_i = 1'b1; mark_i = 1'b1; model_restore();
      @(negedge clk); restore_i = 1'b0; mark_i = 1'b0;
      for (int i = 0; i < 6; i++) request();
      @(negedge clk); restore_i = 1'b1; model_restore();
      @(negedge clk); restore_i = 1'b0;
      for (int i = 0; i < 6; i++) request();

      // R8: skip mode rejects reserved codes, then plain mode delivers them
      @(negedge clk); skip_en_i = 1'b1;
      for (int i = 0; i < 160; i++) request();
      check(n_rejected > 0, "R8 rejections occurred", 36'(n_rejected), 36'o1);
      @(negedge clk); skip_en_i = 1'b0;
      for (int i = 0; i < 160; i++) request();
      check(n_reserved_sent > 0, "R8 reserved words delivered", 36'(n_reserved_sent), 36'o1);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R4 all words seen", 36'(exp_q.size()), 36'o0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule